// File: doc/BRIEF.md
# Exception and interrupt vectoring unit

This block sits in the next-PC and write-back path of a single-cycle processor. It holds the program counter and turns two kinds of trouble into a forced procedure call. The first is an instruction whose opcode decodes to nothing the machine implements, which is a synchronous fault. The second is a request on the external interrupt line, which is an asynchronous event. When either is taken, the unit sends fetch to a fixed low-memory vector. It also makes the register file store the address just after the interrupted instruction in a reserved register, number 30, called the return pointer.

The unit discards the interrupted instruction. Its normal register write and any memory write are suppressed. A handler that wants to run that instruction again must return to the saved value minus 4. The top bit of the program counter is a privilege bit. Entering either vector sets it, and while it is set the interrupt line is ignored, so the return pointer is not overwritten by a nested event. Decode, the ALU, memory and the register file are outside the block.

Top module: `xvec_unit`

## Requirements
- R1: A synchronous reset loads the program counter with 0x80000000, so the unit starts with the privilege bit (bit 31) set.
- R2: When `insn_legal` is 0 and no interrupt is taken, `pc_sel` is 3 and the program counter at the next edge is 0x80000004. This applies in either privilege state.
- R3: When `irq_req` is 1 and PC bit 31 is 0, `pc_sel` is 4 and the program counter at the next edge is 0x80000008.
- R4: While PC bit 31 is 1, `irq_req` has no effect: the outputs and the next program counter are those of the normal flow.
- R5: When an illegal opcode and a taken interrupt arrive in the same cycle, the interrupt wins: `pc_sel` is 4 and the next program counter is 0x80000008.
- R6: Whenever an event is taken, `wa_sel` is 1, `wr_addr` is 30, `wd_sel` is 0 (the return-address source) and `rf_we` is 1, whatever the normal write enable says.
- R7: Whenever an event is taken, `mem_we` is 0.
- R8: With no event taken, `wa_sel` is 0 and `wr_addr` equals `dest_reg`. In the same case `wd_sel`, `rf_we` and `mem_we` equal `norm_wd_sel`, `norm_rf_we` and `norm_mem_we`.
- R9: `pc_ret` equals the program counter with bits 30:0 increased by 4 modulo 2^31 and bit 31 unchanged.
- R10: With no event taken, `norm_pc_sel` chooses the next program counter. 0 or 3 selects `pc_ret`, 1 selects `br_target` and 2 selects `jmp_target`. `pc_sel` reports 0, 0, 1 and 2 for these four values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_legal | input | 1 | Decoder found an implemented opcode |
| irq_req | input | 1 | External interrupt request |
| dest_reg | input | 5 | Destination register field of the instruction |
| norm_pc_sel | input | 2 | Normal next-PC choice from decode |
| br_target | input | 32 | Taken-branch address |
| jmp_target | input | 32 | Register-jump address |
| norm_wd_sel | input | 2 | Normal write-data source from decode |
| norm_rf_we | input | 1 | Normal register write enable |
| norm_mem_we | input | 1 | Normal memory write enable |
| pc | output | 32 | Current program counter |
| pc_ret | output | 32 | Address of the following instruction |
| pc_sel | output | 3 | Effective next-PC select code |
| wa_sel | output | 1 | 1 when the write address is forced to register 30 |
| wr_addr | output | 5 | Register-file write address |
| wd_sel | output | 2 | Write-data source select |
| rf_we | output | 1 | Register-file write enable |
| mem_we | output | 1 | Memory write enable |

## Verification
The assertions check the following on every clock: masking of interrupts under privilege, the priority between the two events, the forced write-back to register 30 with memory writes blocked, and the pass-through of normal controls. They also check that each select code 3 or 4 is followed by the matching vector in the program counter, and that the return address is formed correctly. Only the bench's instruction sequence can show that privilege is lost through a jump and regained through a vector. The same holds for the return address wrapping within the low 31 bits, for a user-mode address 0x4 being kept apart from the privileged vector, and for a reset in mid-run.

// File: rtl/xvec_pkg.sv
package xvec_pkg;

   typedef enum logic [2:0] {
      PCS_INC   = 3'd0,
      PCS_BR    = 3'd1,
      PCS_JMP   = 3'd2,
      PCS_ILLOP = 3'd3,
      PCS_IRQ   = 3'd4
   } pcsel_e;

   typedef enum logic [1:0] {
      WDS_RET = 2'd0,
      WDS_ALU = 2'd1,
      WDS_MEM = 2'd2
   } wdsel_e;

   typedef struct packed {
      logic take_irq;
      logic take_illop;
      logic take_any;
   } event_t;

endpackage

// File: rtl/xvec_arbiter.sv
module xvec_arbiter #(
   parameter bit IRQ_FIRST = 1'b1
) (
   input  logic            insn_legal,
   input  logic            irq_req,
   input  logic            priv,
   output xvec_pkg::event_t ev
);
   logic irq_ok;
   logic bad_op;

   assign irq_ok = irq_req & ~priv;
   assign bad_op = ~insn_legal;

   generate
      if (IRQ_FIRST) begin : g_irq_first
         assign ev.take_irq   = irq_ok;
         assign ev.take_illop = bad_op & ~irq_ok;
      end else begin : g_illop_first
         assign ev.take_illop = bad_op;
         assign ev.take_irq   = irq_ok & ~bad_op;
      end
   endgenerate

   assign ev.take_any = irq_ok | bad_op;
endmodule

// File: rtl/xvec_pc_unit.sv
module xvec_pc_unit #(
   parameter int          XLEN      = 32,
   parameter bit          SUPV_EN   = 1'b1,
   parameter logic [31:0] RESET_PC  = 32'h8000_0000,
   parameter logic [31:0] VEC_ILLOP = 32'h0000_0004,
   parameter logic [31:0] VEC_IRQ   = 32'h0000_0008
) (
   input  logic             clk,
   input  logic             rst,
   input  xvec_pkg::event_t ev,
   input  logic [1:0]       norm_pc_sel,
   input  logic [XLEN-1:0]  br_target,
   input  logic [XLEN-1:0]  jmp_target,
   output logic [XLEN-1:0]  pc,
   output logic [XLEN-1:0]  pc_ret,
   output logic [2:0]       pc_sel,
   output logic             priv
);
   import xvec_pkg::*;

   localparam int              LOW_W    = XLEN - 1;
   localparam logic [XLEN-1:0] PRIV_BIT = {1'b1, {LOW_W{1'b0}}};
   localparam logic [XLEN-1:0] PRIV_OR  = SUPV_EN ? PRIV_BIT : '0;
   localparam logic [XLEN-1:0] ENT_ILL  = VEC_ILLOP[XLEN-1:0] | PRIV_OR;
   localparam logic [XLEN-1:0] ENT_IRQ  = VEC_IRQ[XLEN-1:0] | PRIV_OR;
   localparam logic [XLEN-1:0] RST_VAL  = RESET_PC[XLEN-1:0];

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_d;
   logic [XLEN-1:0] inc;
   pcsel_e          sel;

   generate
      if (SUPV_EN) begin : g_priv
         assign inc  = {pc_q[XLEN-1], pc_q[LOW_W-1:0] + LOW_W'(4)};
         assign priv = pc_q[XLEN-1];
      end else begin : g_flat
         assign inc  = pc_q + XLEN'(4);
         assign priv = 1'b0;
      end
   endgenerate

   always_comb begin
      if (ev.take_irq) begin
         sel  = PCS_IRQ;
         pc_d = ENT_IRQ;
      end else if (ev.take_illop) begin
         sel  = PCS_ILLOP;
         pc_d = ENT_ILL;
      end else begin
         case (norm_pc_sel)
            2'd1: begin
               sel  = PCS_BR;
               pc_d = br_target;
            end
            2'd2: begin
               sel  = PCS_JMP;
               pc_d = jmp_target;
            end
            default: begin
               sel  = PCS_INC;
               pc_d = inc;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RST_VAL;
      else     pc_q <= pc_d;
   end

   assign pc     = pc_q;
   assign pc_ret = inc;
   assign pc_sel = sel;
endmodule

// File: rtl/xvec_wb_unit.sv
module xvec_wb_unit #(
   parameter int RADDR_W = 5,
   parameter int XP_IDX  = 30
) (
   input  xvec_pkg::event_t    ev,
   input  logic [RADDR_W-1:0]  dest_reg,
   input  logic [1:0]          norm_wd_sel,
   input  logic                norm_rf_we,
   input  logic                norm_mem_we,
   output logic                wa_sel,
   output logic [RADDR_W-1:0]  wr_addr,
   output logic [1:0]          wd_sel,
   output logic                rf_we,
   output logic                mem_we
);
   import xvec_pkg::*;

   localparam logic [RADDR_W-1:0] XP_ADDR = RADDR_W'(XP_IDX);

   always_comb begin
      wa_sel = ev.take_any;
      if (ev.take_any) begin
         wr_addr = XP_ADDR;
         wd_sel  = WDS_RET;
         rf_we   = 1'b1;
         mem_we  = 1'b0;
      end else begin
         wr_addr = dest_reg;
         wd_sel  = norm_wd_sel;
         rf_we   = norm_rf_we;
         mem_we  = norm_mem_we;
      end
   end
endmodule

// File: rtl/xvec_unit.sv
module xvec_unit #(
   parameter int          XLEN      = 32,
   parameter int          RADDR_W   = 5,
   parameter int          XP_IDX    = 30,
   parameter bit          SUPV_EN   = 1'b1,
   parameter bit          IRQ_FIRST = 1'b1,
   parameter logic [31:0] RESET_PC  = 32'h8000_0000,
   parameter logic [31:0] VEC_ILLOP = 32'h0000_0004,
   parameter logic [31:0] VEC_IRQ   = 32'h0000_0008
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               insn_legal,
   input  logic               irq_req,
   input  logic [RADDR_W-1:0] dest_reg,
   input  logic [1:0]         norm_pc_sel,
   input  logic [XLEN-1:0]    br_target,
   input  logic [XLEN-1:0]    jmp_target,
   input  logic [1:0]         norm_wd_sel,
   input  logic               norm_rf_we,
   input  logic               norm_mem_we,
   output logic [XLEN-1:0]    pc,
   output logic [XLEN-1:0]    pc_ret,
   output logic [2:0]         pc_sel,
   output logic               wa_sel,
   output logic [RADDR_W-1:0] wr_addr,
   output logic [1:0]         wd_sel,
   output logic               rf_we,
   output logic               mem_we
);
   import xvec_pkg::*;

   generate
      if (XLEN < 8 || XLEN > 32) begin : g_bad_xlen
         $error("xvec_unit: XLEN must lie in 8..32");
      end
      if (XP_IDX < 0 || XP_IDX >= (1 << RADDR_W)) begin : g_bad_xp
         $error("xvec_unit: XP_IDX outside register range");
      end
      if (VEC_ILLOP[1:0] != 2'b00 || VEC_IRQ[1:0] != 2'b00) begin : g_bad_vec
         $error("xvec_unit: vectors must be word aligned");
      end
      if (VEC_ILLOP == VEC_IRQ) begin : g_same_vec
         $error("xvec_unit: vectors must differ");
      end
   endgenerate

   event_t ev;
   logic   priv;

   xvec_arbiter #(
      .IRQ_FIRST (IRQ_FIRST)
   ) u_arb (
      .insn_legal (insn_legal),
      .irq_req    (irq_req),
      .priv       (priv),
      .ev         (ev)
   );

   xvec_pc_unit #(
      .XLEN      (XLEN),
      .SUPV_EN   (SUPV_EN),
      .RESET_PC  (RESET_PC),
      .VEC_ILLOP (VEC_ILLOP),
      .VEC_IRQ   (VEC_IRQ)
   ) u_pc (
      .clk         (clk),
      .rst         (rst),
      .ev          (ev),
      .norm_pc_sel (norm_pc_sel),
      .br_target   (br_target),
      .jmp_target  (jmp_target),
      .pc          (pc),
      .pc_ret      (pc_ret),
      .pc_sel      (pc_sel),
      .priv        (priv)
   );

   xvec_wb_unit #(
      .RADDR_W (RADDR_W),
      .XP_IDX  (XP_IDX)
   ) u_wb (
      .ev          (ev),
      .dest_reg    (dest_reg),
      .norm_wd_sel (norm_wd_sel),
      .norm_rf_we  (norm_rf_we),
      .norm_mem_we (norm_mem_we),
      .wa_sel      (wa_sel),
      .wr_addr     (wr_addr),
      .wd_sel      (wd_sel),
      .rf_we       (rf_we),
      .mem_we      (mem_we)
   );
endmodule

// File: rtl/xvec_checker.sv
module xvec_checker #(
   parameter int XLEN    = 32,
   parameter int RADDR_W = 5
) (
   input logic               clk,
   input logic               rst,
   input logic               insn_legal,
   input logic               irq_req,
   input logic [RADDR_W-1:0] dest_reg,
   input logic               norm_rf_we,
   input logic               norm_mem_we,
   input logic [XLEN-1:0]    pc,
   input logic [XLEN-1:0]    pc_ret,
   input logic [2:0]         pc_sel,
   input logic [RADDR_W-1:0] wr_addr,
   input logic [1:0]         wd_sel,
   input logic               rf_we,
   input logic               mem_we
);
   logic evt;
   assign evt = (pc_sel == 3'd3) || (pc_sel == 3'd4);

   AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == 32'h8000_0000); // R1
   AST_ILLOP_VEC: assert property (@(posedge clk) disable iff (rst)
      pc_sel == 3'd3 |=> pc == 32'h8000_0004); // R2
   AST_IRQ_VEC: assert property (@(posedge clk) disable iff (rst)
      pc_sel == 3'd4 |=> pc == 32'h8000_0008); // R3
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
      pc[XLEN-1] |-> pc_sel != 3'd4); // R4
   AST_IRQ_PRIO: assert property (@(posedge clk) disable iff (rst)
      (!pc[XLEN-1] && irq_req && !insn_legal) |-> pc_sel == 3'd4); // R5
   AST_XP_WRITE: assert property (@(posedge clk) disable iff (rst)
      evt |-> (wr_addr == RADDR_W'(30) && rf_we && wd_sel == 2'd0)); // R6
   AST_NO_MEM_WR: assert property (@(posedge clk) disable iff (rst)
      evt |-> !mem_we); // R7
   AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
      (insn_legal && !(irq_req && !pc[XLEN-1]))
      |-> (wr_addr == dest_reg && rf_we == norm_rf_we && mem_we == norm_mem_we)); // R8
   AST_RET_ADDR: assert property (@(posedge clk) disable iff (rst)
      (pc_ret[XLEN-1] == pc[XLEN-1]) &&
      (pc_ret[XLEN-2:0] == pc[XLEN-2:0] + (XLEN-1)'(4))); // R9
endmodule

bind xvec_unit xvec_checker #(
   .XLEN    (XLEN),
   .RADDR_W (RADDR_W)
) u_xvec_chk (
   .clk         (clk),
   .rst         (rst),
   .insn_legal  (insn_legal),
   .irq_req     (irq_req),
   .dest_reg    (dest_reg),
   .norm_rf_we  (norm_rf_we),
   .norm_mem_we (norm_mem_we),
   .pc          (pc),
   .pc_ret      (pc_ret),
   .pc_sel      (pc_sel),
   .wr_addr     (wr_addr),
   .wd_sel      (wd_sel),
   .rf_we       (rf_we),
   .mem_we      (mem_we)
);

// File: tb/tb_xvec_unit.sv
module tb_xvec_unit;

   typedef struct packed {
      logic        legal;
      logic        irq;
      logic [4:0]  dest;
      logic [1:0]  nsel;
      logic [31:0] tgt;
      logic [1:0]  nwd;
      logic        nwe;
      logic        nmwe;
      logic [31:0] e_pc;
      logic [2:0]  e_sel;
      logic [4:0]  e_wa;
      logic [1:0]  e_wd;
      logic        e_we;
      logic        e_mwe;
      logic [31:0] e_next;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b0,5'd3 ,2'd0,32'h0,        2'd1,1'b1,1'b0,32'h8000_0000,3'd0,5'd3 ,2'd1,1'b1,1'b0,32'h8000_0004},
      '{1'b1,1'b1,5'd5 ,2'd2,32'h0000_0100,2'd1,1'b0,1'b1,32'h8000_0004,3'd2,5'd5 ,2'd1,1'b0,1'b1,32'h0000_0100},
      '{1'b1,1'b0,5'd7 ,2'd1,32'h0000_0200,2'd2,1'b1,1'b0,32'h0000_0100,3'd1,5'd7 ,2'd2,1'b1,1'b0,32'h0000_0200},
      '{1'b0,1'b0,5'd9 ,2'd0,32'h0,        2'd1,1'b0,1'b1,32'h0000_0200,3'd3,5'd30,2'd0,1'b1,1'b0,32'h8000_0004},
      '{1'b0,1'b0,5'd2 ,2'd0,32'h0,        2'd2,1'b0,1'b1,32'h8000_0004,3'd3,5'd30,2'd0,1'b1,1'b0,32'h8000_0004},
      '{1'b1,1'b0,5'd1 ,2'd2,32'h0000_0300,2'd1,1'b1,1'b0,32'h8000_0004,3'd2,5'd1 ,2'd1,1'b1,1'b0,32'h0000_0300},
      '{1'b1,1'b1,5'd4 ,2'd0,32'h0,        2'd2,1'b0,1'b1,32'h0000_0300,3'd4,5'd30,2'd0,1'b1,1'b0,32'h8000_0008},
      '{1'b1,1'b0,5'd6 ,2'd2,32'h0000_0400,2'd1,1'b1,1'b0,32'h8000_0008,3'd2,5'd6 ,2'd1,1'b1,1'b0,32'h0000_0400},
      '{1'b0,1'b1,5'd8 ,2'd0,32'h0,        2'd1,1'b1,1'b1,32'h0000_0400,3'd4,5'd30,2'd0,1'b1,1'b0,32'h8000_0008},
      '{1'b1,1'b0,5'd10,2'd2,32'h7FFF_FFFC,2'd2,1'b0,1'b0,32'h8000_0008,3'd2,5'd10,2'd2,1'b0,1'b0,32'h7FFF_FFFC},
      '{1'b1,1'b0,5'd31,2'd3,32'h0,        2'd2,1'b1,1'b0,32'h7FFF_FFFC,3'd0,5'd31,2'd2,1'b1,1'b0,32'h0000_0000},
      '{1'b1,1'b0,5'd0 ,2'd0,32'h0,        2'd1,1'b0,1'b0,32'h0000_0000,3'd0,5'd0 ,2'd1,1'b0,1'b0,32'h0000_0004},
      '{1'b0,1'b0,5'd12,2'd0,32'h0,        2'd1,1'b0,1'b1,32'h0000_0004,3'd3,5'd30,2'd0,1'b1,1'b0,32'h8000_0004}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        insn_legal = 1'b1;
   logic        irq_req = 1'b0;
   logic [4:0]  dest_reg = '0;
   logic [1:0]  norm_pc_sel = '0;
   logic [31:0] br_target = '0;
   logic [31:0] jmp_target = '0;
   logic [1:0]  norm_wd_sel = '0;
   logic        norm_rf_we = 1'b0;
   logic        norm_mem_we = 1'b0;
   logic [31:0] pc;
   logic [31:0] pc_ret;
   logic [2:0]  pc_sel;
   logic        wa_sel;
   logic [4:0]  wr_addr;
   logic [1:0]  wd_sel;
   logic        rf_we;
   logic        mem_we;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   xvec_unit dut (
      .clk (clk), .rst (rst), .insn_legal (insn_legal), .irq_req (irq_req),
      .dest_reg (dest_reg), .norm_pc_sel (norm_pc_sel), .br_target (br_target),
      .jmp_target (jmp_target), .norm_wd_sel (norm_wd_sel), .norm_rf_we (norm_rf_we),
      .norm_mem_we (norm_mem_we), .pc (pc), .pc_ret (pc_ret), .pc_sel (pc_sel),
      .wa_sel (wa_sel), .wr_addr (wr_addr), .wd_sel (wd_sel), .rf_we (rf_we),
      .mem_we (mem_we)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input vec_t v);
      if (v.e_sel == 3'd4 && !v.legal) return "R5";
      if (v.e_sel == 3'd4)             return "R3";
      if (v.e_sel == 3'd3)             return "R2";
      if (v.irq)                       return "R4";
      return "R10";
   endfunction

   initial begin : watchdog
      repeat (2000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1", "pc after reset", pc, 32'h8000_0000);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = TBL[i];
         insn_legal  = v.legal;
         irq_req     = v.irq;
         dest_reg    = v.dest;
         norm_pc_sel = v.nsel;
         br_target   = (v.nsel == 2'd1) ? v.tgt : 32'hDEAD_BEE0;
         jmp_target  = (v.nsel == 2'd2) ? v.tgt : 32'h0BAD_F00C;
         norm_wd_sel = v.nwd;
         norm_rf_we  = v.nwe;
         norm_mem_we = v.nmwe;
         #1;
         chk(req_of(v), $sformatf("row %0d pc", i), pc, v.e_pc);
         chk(req_of(v), $sformatf("row %0d pc_sel", i), 32'(pc_sel), 32'(v.e_sel));
         chk("R9", $sformatf("row %0d pc_ret", i), pc_ret,
             {v.e_pc[31], v.e_pc[30:0] + 31'd4});
         if (v.e_sel >= 3'd3) begin
            chk("R6", $sformatf("row %0d wa_sel", i), 32'(wa_sel), 32'd1);
            chk("R6", $sformatf("row %0d wr_addr", i), 32'(wr_addr), 32'd30);
            chk("R6", $sformatf("row %0d wd_sel", i), 32'(wd_sel), 32'd0);
            chk("R6", $sformatf("row %0d rf_we", i), 32'(rf_we), 32'd1);
            chk("R7", $sformatf("row %0d mem_we", i), 32'(mem_we), 32'd0);
         end else begin
            chk("R8", $sformatf("row %0d wa_sel", i), 32'(wa_sel), 32'd0);
            chk("R8", $sformatf("row %0d wr_addr", i), 32'(wr_addr), 32'(v.e_wa));
            chk("R8", $sformatf("row %0d wd_sel", i), 32'(wd_sel), 32'(v.e_wd));
            chk("R8", $sformatf("row %0d rf_we", i), 32'(rf_we), 32'(v.e_we));
            chk("R8", $sformatf("row %0d mem_we", i), 32'(mem_we), 32'(v.e_mwe));
         end
         @(negedge clk);
         #1;
         chk(req_of(v), $sformatf("row %0d next pc", i), pc, v.e_next);
      end

      // Directed: leave privilege by a jump, then reset in mid-run (R1)
      insn_legal = 1'b1; irq_req = 1'b0; norm_pc_sel = 2'd2;
      jmp_target = 32'h0000_0500;
      @(negedge clk);
      #1;
      chk("R10", "jump to user code", pc, 32'h0000_0500);
      rst = 1'b1; insn_legal = 1'b0; irq_req = 1'b1;
      @(negedge clk);
      #1;
      chk("R1", "reset overrides events", pc, 32'h8000_0000);
      rst = 1'b0; insn_legal = 1'b1; irq_req = 1'b1; norm_pc_sel = 2'd0;
      #1;
      chk("R4", "irq masked after reset", 32'(pc_sel), 32'd0);
      @(negedge clk);
      #1;
      chk("R4", "pc follows increment", pc, 32'h8000_0004);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule